// File: doc/BRIEF.md
# Core Module System Control Registers

This block is a bank of 32-bit control and status words for a processor core module. A host reaches it over a plain synchronous register bus: a word address, a read strobe, a write strobe and write data. Read data and an error flag come back registered, one clock after the access. The bank holds a fixed identification word and a fixed status word. It has two oscillator words that can only be written after a 16-bit unlock key has been stored. It has a control word that drives an LED bit and a boot-remap level and that can fire a system reset request. It also has two pairs of set/clear flag words, a read-only window of presence-detect bytes, and a one-bit local software interrupt with separate IRQ and FIQ enable masks.

The memory size in megabytes is a parameter. It selects the size code in the reset value of the SDRAM word and the size byte of the presence-detect table. All state loads on a synchronous, active-high reset.

Top module: `coremod_sysregs`

## Requirements
- R1: Word 0 reads 0x411A3001, word 4 reads 0x00100000, word 1 reads 0; writes to these words have no effect.
- R2: After reset: word 2 reads 0x01000048, word 7 reads 0x0007FEFF, word 9 reads 0x00000112, and word 8 reads 0x00011122 ORed with the size code (0x10 at 256 MB or more, 0x0C at 128, 0x08 at 64, 0x04 at 32, else 0x00). After reset, the control word, the LED, the remap level, the interrupt requests and the reset request are all 0.
- R3: A write to word 5 keeps only data bits 15:0. While the stored key is 0xA05F, word 5 reads 0x0001A05F. Otherwise it reads the stored key, zero-extended.
- R4: Writes to word 2 and word 7 update those words only while the stored key is 0xA05F. Otherwise they are ignored.
- R5: A write to word 3 stores data bit 0 (LED output) and data bit 2 (remap_sel output) and drops every other bit. Word 3 reads back only those two bits, and bit 3 always reads 0.
- R6: A write to word 3 with data bit 3 set raises sys_reset_req for exactly the one cycle after the write.
- R7: Word 12 reads the flag word. A write to word 12 ORs the data into it, and a write to word 13 clears the bits that are 1 in the data. Words 14 and 15 do the same for a second flag word read at word 14.
- R8: Words 64 to 95 return the presence-detect byte at index (word - 64), zero-extended. Byte 0 is 0x80, byte 1 is 0x08, and byte 31 is the size byte (64, 32, 16, 4 or 2 for the same size steps as R2). Words 96 to 127 read 0.
- R9: The interrupt level is one bit. A write to word 20 with data bit 0 set sets it, a write to word 21 with data bit 0 set clears it, and word 20 reads it. Words 18/19 set and clear IRQ enable bits, and words 26/27 set and clear FIQ enable bits; words 18 and 26 read the masks.
- R10: Words 16 and 24 read the level ANDed with the IRQ and FIQ masks, and words 17 and 25 read the raw level. irq_req is high when level bit 0 and IRQ enable bit 0 are both set; fiq_req likewise with the FIQ enable.
- R11: Words 32 to 35 read 0 and ignore writes.
- R12: An access to a word outside the mapped set (for example word 6, 10 or 40) reads 0, changes nothing, and raises rsp_err for the one cycle after the access. Mapped accesses leave rsp_err low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe |
| req_addr | input | AW | Word address |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid the cycle after req_rd |
| rsp_err | output | 1 | One-cycle pulse after an unmapped access |
| sys_reset_req | output | 1 | One-cycle system reset request |
| remap_sel | output | 1 | High removes boot flash from address zero |
| led | output | 1 | LED drive bit |
| irq_req | output | 1 | IRQ request |
| fiq_req | output | 1 | FIQ request |

## Verification
The hardest case to reach is an oscillator update: it requires the exact key in the lower half of a wider write word, and then an oscillator write while that key is held. The stimulus first writes an oscillator while the bank is locked. It then stores the key with junk in the upper bits, writes both oscillators, and relocks with a near-miss key before trying once more. Interrupt outputs are driven through every pairing of level and the two masks by set and clear writes issued in differing orders.

// File: rtl/coremod_sysregs.sv
module coremod_sysregs #(
  parameter int MEM_MB = 128,
  parameter int AW     = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_rd,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic [31:0]   rsp_rdata,
  output logic          rsp_err,
  output logic          sys_reset_req,
  output logic          remap_sel,
  output logic          led,
  output logic          irq_req,
  output logic          fiq_req
);

  localparam logic [31:0] ID_WORD   = 32'h411A3001;
  localparam logic [31:0] STAT_WORD = 32'h00100000;
  localparam logic [15:0] KEY       = 16'hA05F;
  localparam logic [31:0] SZ_CODE   = (MEM_MB >= 256) ? 32'h10 : (MEM_MB >= 128) ? 32'h0C :
                                      (MEM_MB >= 64)  ? 32'h08 : (MEM_MB >= 32)  ? 32'h04 : 32'h0;
  localparam logic [7:0]  SPD_SZ    = (MEM_MB >= 256) ? 8'd64 : (MEM_MB >= 128) ? 8'd32 :
                                      (MEM_MB >= 64)  ? 8'd16 : (MEM_MB >= 32)  ? 8'd4  : 8'd2;
  localparam logic [31:0] SDRAM_RST = 32'h00011122 | SZ_CODE;
  localparam int          SPD_BASE  = 64;
  localparam int          SPD_LEN   = 32;
  localparam int          WIN_END   = 128;

  function automatic logic [7:0] spd_byte(input int k);
    case (k)
      0: return 8'h80;   1: return 8'h08;   2: return 8'h04;   3: return 8'h0B;
      4: return 8'h09;   5: return 8'h01;   6: return 8'h40;   8: return 8'h02;
      9: return 8'hA0;  10: return 8'hA0;  13: return 8'h08;  15: return 8'h01;
      16: return 8'h0E; 17: return 8'h04;  18: return 8'h1C;  19: return 8'h01;
      20: return 8'h02; 21: return 8'h20;  22: return 8'hC0;  27: return 8'h30;
      28: return 8'h28; 29: return 8'h30;  30: return 8'h28;  31: return SPD_SZ;
      default: return 8'h00;
    endcase
  endfunction

  logic [31:0] osc_main, osc_aux, sdram_q, init_q, flags_q, nvflags_q, irq_en, fiq_en;
  logic [15:0] lock_q;
  logic        lvl_q;
  logic [31:0] rd_val;
  logic        hit;
  logic        unlocked;
  int unsigned wi;

  assign wi       = 32'(req_addr);
  assign unlocked = (lock_q == KEY);
  assign irq_req  = lvl_q & irq_en[0];
  assign fiq_req  = lvl_q & fiq_en[0];

  always_comb begin
    rd_val = 32'h0;
    hit    = 1'b1;
    case (wi)
      0:  rd_val = ID_WORD;
      1:  rd_val = 32'h0;
      2:  rd_val = osc_main;
      3:  rd_val = {29'h0, remap_sel, 1'b0, led};
      4:  rd_val = STAT_WORD;
      5:  rd_val = unlocked ? 32'h0001A05F : {16'h0, lock_q};
      7:  rd_val = osc_aux;
      8:  rd_val = sdram_q;
      9:  rd_val = init_q;
      12: rd_val = flags_q;
      14: rd_val = nvflags_q;
      16: rd_val = {31'h0, lvl_q & irq_en[0]};
      17: rd_val = {31'h0, lvl_q};
      18: rd_val = irq_en;
      20: rd_val = {31'h0, lvl_q};
      24: rd_val = {31'h0, lvl_q & fiq_en[0]};
      25: rd_val = {31'h0, lvl_q};
      26: rd_val = fiq_en;
      13, 15, 19, 21, 27, 32, 33, 34, 35: rd_val = 32'h0;
      default: begin
        if (wi >= SPD_BASE && wi < WIN_END) begin
          if (wi < SPD_BASE + SPD_LEN) rd_val = {24'h0, spd_byte(int'(wi) - SPD_BASE)};
        end else begin
          hit = 1'b0;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      osc_main      <= 32'h01000048;
      osc_aux       <= 32'h0007FEFF;
      sdram_q       <= SDRAM_RST;
      init_q        <= 32'h00000112;
      flags_q       <= 32'h0;
      nvflags_q     <= 32'h0;
      irq_en        <= 32'h0;
      fiq_en        <= 32'h0;
      lock_q        <= 16'h0;
      lvl_q         <= 1'b0;
      led           <= 1'b0;
      remap_sel     <= 1'b0;
      sys_reset_req <= 1'b0;
      rsp_err       <= 1'b0;
      rsp_rdata     <= 32'h0;
    end else begin
      sys_reset_req <= 1'b0;
      rsp_err       <= (req_rd | req_wr) & ~hit;
      if (req_rd) rsp_rdata <= rd_val;
      if (req_wr) begin
        case (wi)
          2:  if (unlocked) osc_main <= req_wdata;
          3: begin
            led           <= req_wdata[0];
            remap_sel     <= req_wdata[2];
            sys_reset_req <= req_wdata[3];
          end
          5:  lock_q    <= req_wdata[15:0];
          7:  if (unlocked) osc_aux <= req_wdata;
          8:  sdram_q   <= req_wdata;
          9:  init_q    <= req_wdata;
          12: flags_q   <= flags_q | req_wdata;
          13: flags_q   <= flags_q & ~req_wdata;
          14: nvflags_q <= nvflags_q | req_wdata;
          15: nvflags_q <= nvflags_q & ~req_wdata;
          18: irq_en    <= irq_en | req_wdata;
          19: irq_en    <= irq_en & ~req_wdata;
          20: if (req_wdata[0]) lvl_q <= 1'b1;
          21: if (req_wdata[0]) lvl_q <= 1'b0;
          26: fiq_en    <= fiq_en | req_wdata;
          27: fiq_en    <= fiq_en & ~req_wdata;
          default: ;
        endcase
      end
    end
  end

  a_r4_osc_locked: assert property (@(posedge clk) disable iff (rst)
    (!$stable(osc_main) || !$stable(osc_aux)) |-> ($past(lock_q) == KEY));

  a_r5_remap_by_write: assert property (@(posedge clk) disable iff (rst)
    ($rose(remap_sel) || $fell(remap_sel)) |-> $past(req_wr));

  a_r6_reset_from_write: assert property (@(posedge clk) disable iff (rst)
    sys_reset_req |-> $past(req_wr));

  a_r10_irq_needs_level: assert property (@(posedge clk) disable iff (rst)
    (irq_req || fiq_req) |-> lvl_q);

  a_r12_err_after_access: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> $past(req_rd || req_wr));

endmodule

// File: tb/coremod_sysregs_test.sv
`timescale 1ns/1ps
module coremod_sysregs_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_rd = 1'b0, req_wr = 1'b0;
  logic [6:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic        rsp_err, sys_reset_req, remap_sel, led, irq_req, fiq_req;

  int checks = 0, fails = 0;
  logic [31:0] q_d[$];
  bit          q_c[$];
  logic        q_e[$];
  string       q_t[$];
  logic        fired = 1'b0;

  always #2 clk = ~clk;

  coremod_sysregs #(.MEM_MB(128), .AW(7)) uut (
    .clk(clk), .rst(rst), .req_rd(req_rd), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .sys_reset_req(sys_reset_req), .remap_sel(remap_sel), .led(led),
    .irq_req(irq_req), .fiq_req(fiq_req));

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  always @(posedge clk) fired <= req_rd | req_wr;

  always @(negedge clk) begin
    if (fired && q_t.size() > 0) begin
      logic [31:0] d; bit c; logic e; string t;
      d = q_d.pop_front(); c = q_c.pop_front(); e = q_e.pop_front(); t = q_t.pop_front();
      if (c) check({t, " data"}, rsp_rdata, d);
      check({t, " err"}, {31'h0, rsp_err}, {31'h0, e});
    end
  end

  task automatic acc(input bit wr, input int a, input logic [31:0] wd,
                     input logic [31:0] exp, input bit cd, input logic ee, input string tag);
    @(negedge clk);
    req_rd = !wr; req_wr = wr; req_addr = 7'(a); req_wdata = wd;
    q_d.push_back(exp); q_c.push_back(cd); q_e.push_back(ee); q_t.push_back(tag);
    @(posedge clk); #1;
    req_rd = 1'b0; req_wr = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    acc(1'b0, a, 32'h0, exp, 1'b1, 1'b0, tag);
  endtask

  task automatic wr(input int a, input logic [31:0] d, input string tag);
    acc(1'b1, a, d, 32'h0, 1'b0, 1'b0, tag);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    check("R2 led", {31'h0, led}, 32'h0);
    check("R2 remap", {31'h0, remap_sel}, 32'h0);
    check("R2 irq/fiq", {30'h0, irq_req, fiq_req}, 32'h0);
    check("R2 reset req", {31'h0, sys_reset_req}, 32'h0);
    rd(2, 32'h01000048, "R2 osc main");
    rd(7, 32'h0007FEFF, "R2 osc aux");
    rd(8, 32'h0001112E, "R2 sdram");
    rd(9, 32'h00000112, "R2 init");
    rd(3, 32'h0, "R2 ctrl");
    rd(0, 32'h411A3001, "R1 id");
    rd(4, 32'h00100000, "R1 status");
    rd(1, 32'h0, "R1 word1");
    wr(0, 32'hFFFFFFFF, "R1 write id");
    rd(0, 32'h411A3001, "R1 id after write");

    wr(2, 32'h12345678, "R4 locked write");
    rd(2, 32'h01000048, "R4 locked osc main");
    wr(5, 32'hBEEFA05F, "R3 unlock");
    rd(5, 32'h0001A05F, "R3 unlocked read");
    wr(2, 32'hCAFE0001, "R4 osc main");
    wr(7, 32'hCAFE0007, "R4 osc aux");
    rd(2, 32'hCAFE0001, "R4 osc main updated");
    rd(7, 32'hCAFE0007, "R4 osc aux updated");
    wr(5, 32'h0000A05E, "R3 near key");
    rd(5, 32'h0000A05E, "R3 locked read");
    wr(7, 32'h11111111, "R4 relocked write");
    rd(7, 32'hCAFE0007, "R4 aux unchanged");

    wr(3, 32'hFFFFFFFF, "R5 ctrl all ones");
    check("R6 reset pulse", {31'h0, sys_reset_req}, 32'h1);
    check("R5 led", {31'h0, led}, 32'h1);
    check("R5 remap", {31'h0, remap_sel}, 32'h1);
    @(posedge clk); #1;
    check("R6 reset pulse ends", {31'h0, sys_reset_req}, 32'h0);
    rd(3, 32'h5, "R5 ctrl readback");
    wr(3, 32'h00000004, "R5 keep remap");
    check("R5 remap held", {31'h0, remap_sel}, 32'h1);
    check("R5 led off", {31'h0, led}, 32'h0);
    check("R6 no reset", {31'h0, sys_reset_req}, 32'h0);
    wr(3, 32'h00000008, "R6 reset only");
    check("R6 reset pulse 2", {31'h0, sys_reset_req}, 32'h1);
    check("R5 remap cleared", {31'h0, remap_sel}, 32'h0);

    wr(12, 32'h000000F0, "R7 flag set");
    wr(12, 32'h00000101, "R7 flag set 2");
    wr(13, 32'h00000030, "R7 flag clr");
    rd(12, 32'h000001C1, "R7 flags");
    wr(14, 32'hA0000005, "R7 nv set");
    wr(15, 32'h80000001, "R7 nv clr");
    rd(14, 32'h20000004, "R7 nvflags");

    rd(64, 32'h80, "R8 spd byte0");
    rd(65, 32'h08, "R8 spd byte1");
    rd(95, 32'd32, "R8 spd size byte");
    rd(96, 32'h0, "R8 window zero");
    rd(127, 32'h0, "R8 window end");

    wr(18, 32'h00000001, "R9 irq en");
    check("R10 no level", {30'h0, irq_req, fiq_req}, 32'h0);
    wr(20, 32'h00000003, "R9 level set");
    check("R10 irq only", {30'h0, irq_req, fiq_req}, 32'h2);
    rd(20, 32'h1, "R9 level read");
    rd(16, 32'h1, "R10 irq status");
    rd(17, 32'h1, "R10 irq raw");
    rd(24, 32'h0, "R10 fiq status");
    wr(26, 32'h00000003, "R9 fiq en");
    rd(26, 32'h3, "R9 fiq mask");
    check("R10 both", {30'h0, irq_req, fiq_req}, 32'h3);
    wr(19, 32'h00000001, "R9 irq clr");
    check("R10 fiq only", {30'h0, irq_req, fiq_req}, 32'h1);
    rd(18, 32'h0, "R9 irq mask");
    wr(21, 32'h00000000, "R9 clr without bit0");
    rd(25, 32'h1, "R10 fiq raw");
    wr(21, 32'h00000001, "R9 level clr");
    check("R10 none", {30'h0, irq_req, fiq_req}, 32'h0);
    rd(20, 32'h0, "R9 level cleared");

    wr(33, 32'hFFFFFFFF, "R11 voltage write");
    rd(33, 32'h0, "R11 voltage read");

    acc(1'b0, 6, 32'h0, 32'h0, 1'b1, 1'b1, "R12 unmapped read 6");
    acc(1'b1, 40, 32'hFFFFFFFF, 32'h0, 1'b0, 1'b1, "R12 unmapped write 40");
    acc(1'b0, 10, 32'h0, 32'h0, 1'b1, 1'b1, "R12 unmapped read 10");
    rd(12, 32'h000001C1, "R12 flags untouched");

    @(negedge clk); @(negedge clk);
    if (q_t.size() != 0) check("scoreboard drained", q_t.size(), 0);
    finish_run();
  end
endmodule